// File: doc/BRIEF.md
# Audio Sample Format Converter

This block sits between an audio client and a routing hub. It takes multichannel audio frames in one format and emits them in another, converting both the sample width (4 to 32 bits, in steps of 4) and the channel count (1 to 8). Samples travel left-aligned in a 32-bit lane, most significant bit at bit 31.

A 20-bit control word describes the client side and the hub side: a width and a channel count for each. It also sets the fill used when widening, the narrowing method, the stereo-to-mono and mono-to-stereo rules, replication of the last channel, and the direction. The direction picks which side is the input. The word is captured when the first sample of a frame is accepted, and it holds until that frame has left the block.

The block works one frame at a time. It stores one input frame, which ends with the sample marked last. It then emits one output frame whose final beat carries the last marker. Both streams use valid/ready. The source may hold `s_valid` for as long as it likes, and a sample moves only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high only while the block is collecting, and low while it is emitting. The sink may hold `m_ready` low for any number of cycles. While it does, `m_data` and `m_last` stay unchanged.

Top module: `afc_format_conv`

## Requirements
- R1: Width code c in [0,7] means 4*(c+1) bits. The input sample is masked to its width. Every output lane bit below the output width is 0.
- R2: Fill code (cfg[13:12]) sets the new low bits when a sample is widened. 0 means zeros, 1 means ones, and 2 means the lane bits of {L,L}, where L is a 16-bit LFSR (next = {L[14:0], L[15]^L[13]^L[12]^L[10]}, seed 16'hACE1 at reset). Code 3 acts as 0. L advances once per accepted sample that is widened, after its value is used.
- R3: Narrowing with chop (cfg[16]=1) keeps the top bits of the sample. Narrowing with round (cfg[16]=0) first adds half an output LSB. A positive result that overflows saturates to the largest positive value of the output width.
- R4: A 2-channel input to a 1-channel output is decided by cfg[15:14]. 1 takes channel 1, 2 takes the sign-extended sum of both channels shifted right by one, and 0 or 3 takes channel 0.
- R5: A 1-channel input to a 2-channel output gives channel 0 followed by either zero (cfg[17]=0) or a copy of channel 0 (cfg[17]=1).
- R6: Otherwise, output channel k takes input channel k. Channels at or above the input count are 0, or repeat the last input channel when cfg[18]=1. Input channels beyond the output count are dropped.
- R7: Direction is cfg[19]. With 0 the input uses the client fields (width cfg[2:0], count-1 cfg[8:6]) and the output uses the hub fields (width cfg[5:3], count-1 cfg[11:9]). With 1 the roles swap.
- R8: The control word is taken on the first accepted sample of a frame. Changes to it later in the frame have no effect on that frame.
- R9: The input is accepted only while collecting, and the output is offered only while emitting, so the two never overlap. A stalled output keeps its data and last marker.
- R10: Each output frame has exactly the output channel count of beats, and `m_last` is high on the final beat only.
- R11: After reset, `m_valid` is 0 and `s_ready` is 1.
- R12: An input frame ends at `s_last`. Channels that did not arrive read as 0. Samples after the eighth are discarded, though they still advance the LFSR when widened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 20 | Conversion control word |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block accepts an input sample |
| s_data | input | 32 | Left-aligned input sample |
| s_last | input | 1 | Input sample ends its frame |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Sink accepts an output sample |
| m_data | output | 32 | Left-aligned output sample |
| m_last | output | 1 | Output sample ends its frame |

## Verification
Random control words with random samples reach every pairing of widths and channel counts. Stalls on `m_ready` at random test that the output holds still under back-pressure. Fixed samples near full scale (0x7FFFFFFF, 0x80000000, 0x12C00000) separate rounding from chopping and show saturation, and the LFSR fill case exposes a wrong tap set or a wrong step rule. Short and long frames, changes to the control word in mid-frame, and swapping the direction bit check that the frame boundary, the latch point and the choice of input side are decided correctly.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int LANE_W    = 32;
  localparam int CH_CODE_W = 3;
  localparam int MAX_CH    = 2 ** CH_CODE_W;
  localparam int CFG_W     = 20;
  localparam int RND_W     = 16;

  localparam logic [1:0] FILL_ONE  = 2'd1;
  localparam logic [1:0] FILL_RAND = 2'd2;
  localparam logic [1:0] PICK_RIGHT = 2'd1;
  localparam logic [1:0] PICK_AVG   = 2'd2;

  typedef struct packed {
    logic                 dir;
    logic                 rep;
    logic                 mono_copy;
    logic                 chop;
    logic [1:0]           s2m;
    logic [1:0]           fill;
    logic [CH_CODE_W-1:0] hub_chm1;
    logic [CH_CODE_W-1:0] cli_chm1;
    logic [2:0]           hub_wc;
    logic [2:0]           cli_wc;
  } afc_cfg_t;

  function automatic logic [5:0] width_of(input logic [2:0] code);
    return {1'b0, code, 2'b00} + 6'd4;
  endfunction

  // ones below the given width inside the lane
  function automatic logic [LANE_W-1:0] low_mask(input logic [5:0] w);
    return {LANE_W{1'b1}} >> w;
  endfunction
endpackage

// File: rtl/afc_lfsr.sv
module afc_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [15:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {state[14:0], state[15] ^ state[13] ^ state[12] ^ state[10]};
  end
endmodule

// File: rtl/afc_width_conv.sv
module afc_width_conv
  import afc_pkg::*;
(
  input  logic [LANE_W-1:0] din,
  input  logic [2:0]        in_wc,
  input  logic [2:0]        out_wc,
  input  logic [1:0]        fill,
  input  logic              chop,
  input  logic [RND_W-1:0]  rnd,
  output logic [LANE_W-1:0] dout,
  output logic              widen
);
  logic [5:0]        iw, ow;
  logic [LANE_W-1:0] in_keep, out_keep, x, pat, half, sum;
  logic              ovf;

  always_comb begin
    iw       = width_of(in_wc);
    ow       = width_of(out_wc);
    in_keep  = ~low_mask(iw);
    out_keep = ~low_mask(ow);
    x        = din & in_keep;
    widen    = ow > iw;
    if (fill == FILL_ONE)       pat = '1;
    else if (fill == FILL_RAND) pat = {rnd, rnd};
    else                        pat = '0;
    half = {1'b1, {(LANE_W-1){1'b0}}} >> ow;
    sum  = x + half;
    ovf  = !x[LANE_W-1] && sum[LANE_W-1];
    if (widen)            dout = x | (pat & ~in_keep & out_keep);
    else if (ow < iw) begin
      if (chop)           dout = x & out_keep;
      else if (ovf)       dout = {1'b0, {(LANE_W-1){1'b1}}} & out_keep;
      else                dout = sum & out_keep;
    end else              dout = x;
  end
endmodule

// File: rtl/afc_chan_map.sv
module afc_chan_map
  import afc_pkg::*;
#(
  parameter int CNT_W = $clog2(MAX_CH + 1)
) (
  input  logic [LANE_W-1:0]    lanes [MAX_CH],
  input  logic [CNT_W-1:0]     n_rx,
  input  logic [CH_CODE_W-1:0] in_m1,
  input  logic [CH_CODE_W-1:0] out_m1,
  input  logic [CH_CODE_W-1:0] k,
  input  logic [1:0]           s2m,
  input  logic                 mono_copy,
  input  logic                 rep,
  input  logic [2:0]           out_wc,
  output logic [LANE_W-1:0]    dout
);
  logic [LANE_W-1:0] vis [MAX_CH];
  logic [LANE_W:0]   pair_sum;
  logic [LANE_W-1:0] avg;

  // channels that never arrived in this frame read as zero
  for (genvar g = 0; g < MAX_CH; g++) begin : g_vis
    assign vis[g] = (CNT_W'(g) < n_rx) ? lanes[g] : '0;
  end

  always_comb begin
    pair_sum = {vis[0][LANE_W-1], vis[0]} + {vis[1][LANE_W-1], vis[1]};
    avg      = pair_sum[LANE_W:1] & ~low_mask(width_of(out_wc));
    if (in_m1 == 1 && out_m1 == 0) begin
      if (s2m == PICK_RIGHT)    dout = vis[1];
      else if (s2m == PICK_AVG) dout = avg;
      else                      dout = vis[0];
    end else if (in_m1 == 0 && out_m1 == 1) begin
      dout = (k == 0 || mono_copy) ? vis[0] : '0;
    end else if (k <= in_m1) begin
      dout = vis[k];
    end else begin
      dout = rep ? vis[in_m1] : '0;
    end
  end
endmodule

// File: rtl/afc_format_conv.sv
module afc_format_conv
  import afc_pkg::*;
#(
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [LANE_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [LANE_W-1:0] m_data,
  output logic              m_last
);
  localparam int CNT_W = $clog2(MAX_CH + 1);

  typedef enum logic {ST_FILL, ST_DRAIN} st_t;

  st_t                  st;
  logic [CNT_W-1:0]     rx_cnt;
  logic [CH_CODE_W-1:0] tx_idx;
  logic [LANE_W-1:0]    lane_q [MAX_CH];
  afc_cfg_t             cfg_q, cfg_act;
  logic                 idle, accept, emit, widen;
  logic [LANE_W-1:0]    conv_out;
  logic [15:0]          lfsr_q;
  logic [2:0]           in_wc_act, out_wc_act, out_wc_q;
  logic [CH_CODE_W-1:0] in_m1_q, out_m1_q;

  assign idle    = (st == ST_FILL) && (rx_cnt == '0);
  assign cfg_act = idle ? afc_cfg_t'(cfg_word) : cfg_q;
  assign s_ready = (st == ST_FILL);
  assign m_valid = (st == ST_DRAIN);
  assign accept  = s_valid && s_ready;
  assign emit    = m_valid && m_ready;

  assign in_wc_act  = cfg_act.dir ? cfg_act.hub_wc : cfg_act.cli_wc;
  assign out_wc_act = cfg_act.dir ? cfg_act.cli_wc : cfg_act.hub_wc;
  assign out_wc_q   = cfg_q.dir ? cfg_q.cli_wc   : cfg_q.hub_wc;
  assign in_m1_q    = cfg_q.dir ? cfg_q.hub_chm1 : cfg_q.cli_chm1;
  assign out_m1_q   = cfg_q.dir ? cfg_q.cli_chm1 : cfg_q.hub_chm1;
  assign m_last     = (tx_idx == out_m1_q);

  afc_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(accept && widen), .state(lfsr_q)
  );

  afc_width_conv u_wconv (
    .din(s_data), .in_wc(in_wc_act), .out_wc(out_wc_act), .fill(cfg_act.fill),
    .chop(cfg_act.chop), .rnd(lfsr_q), .dout(conv_out), .widen(widen)
  );

  for (genvar g = 0; g < MAX_CH; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   lane_q[g] <= '0;
      else if (accept && rx_cnt == CNT_W'(g))       lane_q[g] <= conv_out;
    end
  end

  afc_chan_map #(.CNT_W(CNT_W)) u_cmap (
    .lanes(lane_q), .n_rx(rx_cnt), .in_m1(in_m1_q), .out_m1(out_m1_q), .k(tx_idx),
    .s2m(cfg_q.s2m), .mono_copy(cfg_q.mono_copy), .rep(cfg_q.rep),
    .out_wc(out_wc_q), .dout(m_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_FILL;
      rx_cnt <= '0;
      tx_idx <= '0;
      cfg_q  <= '0;
    end else begin
      cfg_q <= cfg_act;
      if (accept) begin
        if (rx_cnt != CNT_W'(MAX_CH)) rx_cnt <= rx_cnt + 1'b1;
        if (s_last) st <= ST_DRAIN;
      end
      if (emit) begin
        if (m_last) begin
          st     <= ST_FILL;
          rx_cnt <= '0;
          tx_idx <= '0;
        end else begin
          tx_idx <= tx_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/afc_format_conv_chk.sv
module afc_format_conv_chk
  import afc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [LANE_W-1:0] m_data,
  input logic              m_last,
  input afc_cfg_t          cfg_q,
  input logic [15:0]       lfsr_q
);
  logic [3:0]           beat;
  logic [CH_CODE_W-1:0] out_m1;
  logic [2:0]           out_wc;

  assign out_m1 = cfg_q.dir ? cfg_q.cli_chm1 : cfg_q.hub_chm1;
  assign out_wc = cfg_q.dir ? cfg_q.cli_wc   : cfg_q.hub_wc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               beat <= '0;
    else if (m_valid && m_ready && m_last)    beat <= '0;
    else if (m_valid && m_ready)              beat <= beat + 1'b1;
  end

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid));
  a_r10_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_last |-> beat == {1'b0, out_m1});
  a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> beat <= {1'b0, out_m1});
  a_r1_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_data & low_mask(width_of(out_wc))) == '0);
  a_r2_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0);
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && $past(m_valid) |-> $stable(cfg_q));
endmodule

bind afc_format_conv afc_format_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last), .cfg_q(cfg_q), .lfsr_q(lfsr_q)
);

// File: tb/afc_format_conv_bench.sv
`timescale 1ns/1ps
module afc_format_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] cfg_word = '0;
  logic        s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, m_valid, m_last;
  logic [31:0] m_data;

  int          n_cmp = 0, n_bad = 0;
  logic [15:0] lfsr_m;
  logic [31:0] cbuf [8];
  int          nrx;
  bit          fix_en = 0;
  logic [31:0] fix_val = '0;

  always #2.5 clk = ~clk;

  afc_format_conv u_afc_format_conv (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input logic [2:0] c);
    return (int'(c) + 1) * 4;
  endfunction

  function automatic logic [15:0] lnext(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  // integer-domain model of the width conversion
  function automatic logic [31:0] mconv(input logic [31:0] x, input int iw, input int ow,
                                        input logic [1:0] fill, input bit chop, input logic [15:0] l);
    longint v, r, f, mx;
    int d;
    v = longint'($signed(x)) >>> (32 - iw);
    if (ow > iw) begin
      d = ow - iw;
      if (fill == 2'd1)      f = (longint'(1) << d) - 1;
      else if (fill == 2'd2) f = (longint'({l, l}) >> (32 - ow)) & ((longint'(1) << d) - 1);
      else                   f = 0;
      r = (v << d) | f;
    end else if (ow < iw) begin
      d = iw - ow;
      if (chop) r = v >>> d;
      else begin
        r  = (v + (longint'(1) << (d - 1))) >>> d;
        mx = (longint'(1) << (ow - 1)) - 1;
        if (r > mx) r = mx;
      end
    end else r = v;
    return 32'(r << (32 - ow));
  endfunction

  function automatic logic [31:0] mpick(input int i);
    return (i < nrx) ? cbuf[i] : 32'h0;
  endfunction

  function automatic logic [31:0] mexp(input logic [19:0] c, input int k);
    int ni, no, ow;
    longint a, b;
    logic [31:0] keep;
    ni = c[19] ? int'(c[11:9]) + 1 : int'(c[8:6]) + 1;
    no = c[19] ? int'(c[8:6]) + 1 : int'(c[11:9]) + 1;
    ow = c[19] ? wbits(c[2:0]) : wbits(c[5:3]);
    keep = 32'hFFFF_FFFF << (32 - ow);
    if (ni == 2 && no == 1) begin
      if (c[15:14] == 2'd1) return mpick(1);
      if (c[15:14] == 2'd2) begin
        a = longint'($signed(mpick(0)));
        b = longint'($signed(mpick(1)));
        return 32'((a + b) >>> 1) & keep;
      end
      return mpick(0);
    end
    if (ni == 1 && no == 2) return (k == 0 || c[17]) ? mpick(0) : 32'h0;
    if (k < ni) return mpick(k);
    return c[18] ? mpick(ni - 1) : 32'h0;
  endfunction

  function automatic logic [19:0] mk(input int cw, input int hw, input int cc, input int hc,
                                     input int fill, input int s2m, input int chop,
                                     input int mono, input int rep, input int dir);
    logic [19:0] r;
    r[2:0]   = 3'(cw);      r[5:3]   = 3'(hw);
    r[8:6]   = 3'(cc - 1);  r[11:9]  = 3'(hc - 1);
    r[13:12] = 2'(fill);    r[15:14] = 2'(s2m);
    r[16] = 1'(chop); r[17] = 1'(mono); r[18] = 1'(rep); r[19] = 1'(dir);
    return r;
  endfunction

  task automatic run_frame(input logic [19:0] c, input int nsend, input bit chg, input string tag);
    int iw, ow, no;
    iw = c[19] ? wbits(c[5:3]) : wbits(c[2:0]);
    ow = c[19] ? wbits(c[2:0]) : wbits(c[5:3]);
    no = c[19] ? int'(c[8:6]) + 1 : int'(c[11:9]) + 1;
    @(negedge clk);
    cfg_word = c;
    nrx = 0;
    for (int j = 0; j < 8; j++) cbuf[j] = '0;
    for (int i = 0; i < nsend; i++) begin
      logic [31:0] d;
      logic [31:0] cv;
      bit r;
      d = fix_en ? fix_val : $urandom;
      s_valid = 1'b1; s_data = d; s_last = (i == nsend - 1);
      do begin
        r = s_ready;
        @(posedge clk); @(negedge clk);
      end while (!r);
      cv = mconv(d, iw, ow, c[13:12], c[16], lfsr_m);
      if (ow > iw) lfsr_m = lnext(lfsr_m);
      if (i < 8) begin cbuf[i] = cv; nrx = i + 1; end
      if (chg && i == 0) cfg_word = $urandom;
    end
    s_valid = 1'b0; s_last = 1'b0;
    for (int k = 0; k < no; k++) begin
      bit done;
      done = 0;
      while (!done) begin
        m_ready = ($urandom % 4) != 0;
        if (m_valid && m_ready) begin
          chk(tag, m_data, mexp(c, k));
          chk("R10", 32'(m_last), 32'(k == no - 1));
          chk("R9", 32'(s_ready), 32'h0);
          done = 1;
        end
        @(posedge clk); @(negedge clk);
      end
    end
    m_ready = 1'b0;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    lfsr_m = 16'hACE1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11", 32'(m_valid), 32'h0);
    chk("R11", 32'(s_ready), 32'h1);
    rst_n = 1'b1;

    // R2: widening fills
    run_frame(mk(3, 7, 2, 2, 1, 0, 0, 0, 0, 0), 2, 0, "R2");
    run_frame(mk(1, 5, 2, 2, 2, 0, 0, 0, 0, 0), 2, 0, "R2");
    run_frame(mk(1, 5, 2, 2, 0, 0, 0, 0, 0, 0), 2, 0, "R2");
    run_frame(mk(0, 7, 3, 3, 2, 0, 0, 0, 0, 0), 3, 0, "R2");
    // R3: narrowing, round vs chop, saturation
    fix_en = 1;
    fix_val = 32'h7FFF_FFFF;
    run_frame(mk(7, 1, 1, 1, 0, 0, 0, 0, 0, 0), 1, 0, "R3");
    run_frame(mk(7, 1, 1, 1, 0, 0, 1, 0, 0, 0), 1, 0, "R3");
    fix_val = 32'h12C0_0000;
    run_frame(mk(7, 1, 1, 1, 0, 0, 0, 0, 0, 0), 1, 0, "R3");
    run_frame(mk(7, 1, 1, 1, 0, 0, 1, 0, 0, 0), 1, 0, "R3");
    fix_val = 32'h8000_0000;
    run_frame(mk(7, 3, 1, 1, 0, 0, 0, 0, 0, 0), 1, 0, "R3");
    fix_en = 0;
    // R4: stereo to mono
    for (int m = 0; m < 4; m++) run_frame(mk(3, 3, 2, 1, 0, m, 0, 0, 0, 0), 2, 0, "R4");
    // R5: mono to stereo
    run_frame(mk(3, 3, 1, 2, 0, 0, 0, 0, 0, 0), 1, 0, "R5");
    run_frame(mk(3, 3, 1, 2, 0, 0, 0, 1, 0, 0), 1, 0, "R5");
    // R6: widen channel count, replicate or zero; drop extras
    run_frame(mk(3, 3, 3, 6, 0, 0, 0, 0, 0, 0), 3, 0, "R6");
    run_frame(mk(3, 3, 3, 6, 0, 0, 0, 0, 1, 0), 3, 0, "R6");
    run_frame(mk(3, 3, 6, 2, 0, 0, 0, 0, 1, 0), 6, 0, "R6");
    // R7: direction swap
    run_frame(mk(7, 3, 2, 4, 1, 0, 0, 0, 0, 1), 4, 0, "R7");
    run_frame(mk(2, 6, 5, 1, 0, 0, 0, 0, 0, 1), 1, 0, "R7");
    // R8: control word changes mid-frame
    for (int t = 0; t < 6; t++) run_frame(mk(1, 6, 4, 3, 2, 0, 0, 0, 1, t % 2), 4, 1, "R8");
    // R12: short and long frames
    run_frame(mk(3, 3, 3, 3, 0, 0, 0, 0, 0, 0), 1, 0, "R12");
    run_frame(mk(1, 3, 8, 8, 2, 0, 0, 0, 0, 0), 10, 0, "R12");
    // R1: random formats
    for (int f = 0; f < 300; f++) begin
      logic [19:0] c;
      int ni, ns;
      c  = 20'($urandom);
      ni = c[19] ? int'(c[11:9]) + 1 : int'(c[8:6]) + 1;
      ns = (($urandom % 10) == 0) ? int'($urandom % 10) + 1 : ni;
      run_frame(c, ns, ($urandom % 10) == 0, "R1");
    end
    finish_up();
  end
endmodule